// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block closes the digital half of a peak-current loop for a motor phase bridge. A comparator outside the block raises `trip_i` when winding current reaches its limit. The block then drops `src_en_o`, which gates the high-side driver chosen by the commutation logic, and keeps it low for a fixed number of clock cycles while the current recirculates. When that time runs out, the source turns back on. For a programmable number of cycles after each turn-on, the comparator is ignored, so a reverse-recovery spike cannot cause a false trip.

The external speed input `pwm_i` is asynchronous. It is synchronized and then ANDed with the internal trip latch, so a PWM-low interval turns the source off and a PWM input held high leaves the current limit in charge. A turn-on also happens when PWM rises or when a commutation strobe switches to a new high-side device, and each of these events starts a blanking window. The off-time and blank-time are loaded as cycle counts. For a clock of f MHz, a 10 µs minimum off-time corresponds to 10·f cycles.

Top module: `fot_chopper`

## Requirements
- R1: During and after a synchronous reset, with PWM still low, `src_en_o`, `chop_off_o` and `blanking_o` are all 0. The latch resets to enabled and both counters reset to zero.
- R2: `pwm_i` passes through a synchronizer of `SYNC_STAGES` flops (default 2), so a change shows at `src_en_o` in the second cycle after it is driven. `src_en_o` equals the synchronized PWM ANDed with the latch. While PWM is low, `src_en_o` is 0.
- R3: A trip sampled while `src_en_o` is 1, `blanking_o` is 0, and there is no turn-on event (`comm_i` or PWM rise) sets `chop_off_o` to 1 and `src_en_o` to 0 in the next cycle. They stay that way for exactly `off_cycles_i` cycles.
- R4: An off-time count of 0 behaves as an off-time of 1 cycle.
- R5: A trip asserted during the off-time neither restarts nor extends it.
- R6: When the off-time ends, `blanking_o` is 1 for exactly `blank_cycles_i` cycles. A trip held during that window is ignored. A trip still present in the first cycle after the window is accepted.
- R7: A rising edge of the synchronized PWM starts a blanking window of `blank_cycles_i` cycles, beginning one cycle after `src_en_o` rises. A `comm_i` pulse while the source latch is on also restarts the window, starting in the next cycle. A `comm_i` pulse during the off-time does not change the off-time.
- R8: With `blank_cycles_i` = 0 no blanking occurs, and a trip in the first cycle after turn-on is accepted.
- R9: A trip while the synchronized PWM is low is ignored (`chop_off_o` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Over-current comparator flag, synchronous |
| pwm_i | input | 1 | External PWM speed input, asynchronous |
| comm_i | input | 1 | One-cycle commutation event strobe |
| off_cycles_i | input | CNT_W | Off-time in cycles (0 treated as 1) |
| blank_cycles_i | input | CNT_W | Blanking time in cycles |
| src_en_o | output | 1 | High-side source enable |
| chop_off_o | output | 1 | High while the fixed off-time runs |
| blanking_o | output | 1 | High while the comparator is masked |

## Verification
The bench sweeps off-times including 0 and 1 against blank-times including 0, and counts the exact length of each off-time and blanking window in cycles. The trip is held high across the whole off-time and the whole blanking window. A design that restarted the timer on a repeated trip would then show a longer off-time, and one that leaked trips through the mask would re-chop early. It also checks that a trip in the first cycle after the mask ends is accepted: an off-by-one in the blank counter would either swallow that trip or accept one a cycle too soon. Commutation pulses during the off-time, trips while PWM is low, and the synchronizer latency are also checked. A design that failed to gate on PWM, or that extended the off-time on a strobe, shows up as a wrong cycle count.

// File: rtl/fot_chopper.sv
module fot_chopper #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             pwm_i,
  input  logic             comm_i,
  input  logic [CNT_W-1:0] off_cycles_i,
  input  logic [CNT_W-1:0] blank_cycles_i,
  output logic             src_en_o,
  output logic             chop_off_o,
  output logic             blanking_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [SYNC_STAGES-1:0] pwm_sync;
  logic                   pwm_q;
  logic                   latch_on;
  logic [CNT_W-1:0]       off_cnt;
  logic [CNT_W-1:0]       blank_cnt;

  logic             pwm_s;
  logic             pwm_rise;
  logic             restart;
  logic             trip_ok;
  logic [CNT_W-1:0] off_load;

  assign pwm_s    = pwm_sync[SYNC_STAGES-1];
  assign pwm_rise = pwm_s & ~pwm_q;
  assign restart  = comm_i | pwm_rise;
  assign trip_ok  = trip_i & pwm_s & (blank_cnt == '0);
  assign off_load = (off_cycles_i == '0) ? ONE : off_cycles_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_sync  <= '0;
      pwm_q     <= 1'b0;
      latch_on  <= 1'b1;
      off_cnt   <= '0;
      blank_cnt <= '0;
    end else begin
      pwm_sync <= {pwm_sync[SYNC_STAGES-2:0], pwm_i};
      pwm_q    <= pwm_s;
      if (!latch_on) begin
        if (off_cnt <= ONE) begin
          latch_on  <= 1'b1;
          off_cnt   <= '0;
          blank_cnt <= blank_cycles_i;
        end else begin
          off_cnt <= off_cnt - ONE;
        end
      end else if (restart) begin
        blank_cnt <= blank_cycles_i;
      end else if (trip_ok) begin
        latch_on <= 1'b0;
        off_cnt  <= off_load;
      end else if (blank_cnt != '0) begin
        blank_cnt <= blank_cnt - ONE;
      end
    end
  end

  assign src_en_o   = latch_on & pwm_s;
  assign chop_off_o = ~latch_on;
  assign blanking_o = latch_on & (blank_cnt != '0);

endmodule

// File: rtl/fot_chopper_chk.sv
module fot_chopper_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trip_i,
  input logic             comm_i,
  input logic [CNT_W-1:0] blank_cycles_i,
  input logic             src_en_o,
  input logic             chop_off_o,
  input logic             blanking_o,
  input logic             pwm_s,
  input logic             pwm_rise,
  input logic [CNT_W-1:0] off_cnt
);

  a_r3_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    src_en_o && !blanking_o && trip_i && !comm_i && !pwm_rise |=> chop_off_o && !src_en_o);

  a_r5_off_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    chop_off_o && off_cnt > CNT_W'(1) |=> chop_off_o && off_cnt == $past(off_cnt) - CNT_W'(1));

  a_r4_off_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chop_off_o) |-> off_cnt != '0);

  a_r2_gating: assert property (@(posedge clk) disable iff (!rst_n)
    src_en_o |-> pwm_s && !chop_off_o);

  a_r6_blank_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chop_off_o) && $past(blank_cycles_i) != '0 |-> blanking_o);

  a_r9_pwm_low_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_s && !chop_off_o |=> !chop_off_o);

endmodule

bind fot_chopper fot_chopper_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .comm_i(comm_i),
  .blank_cycles_i(blank_cycles_i), .src_en_o(src_en_o),
  .chop_off_o(chop_off_o), .blanking_o(blanking_o),
  .pwm_s(pwm_s), .pwm_rise(pwm_rise), .off_cnt(off_cnt)
);

// File: tb/tb_fot_chopper.sv
module tb_fot_chopper;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, pwm = 1'b0, comm = 1'b0;
  logic [W-1:0] off_cfg = '0, blank_cfg = '0;
  logic src_en, chop_off, blanking;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  fot_chopper #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .pwm_i(pwm), .comm_i(comm),
    .off_cycles_i(off_cfg), .blank_cycles_i(blank_cfg),
    .src_en_o(src_en), .chop_off_o(chop_off), .blanking_o(blanking)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s off=%0d blank=%0d actual=%0d expected=%0d",
               req, off_cfg, blank_cfg, act, exp);
    end
  endtask

  function automatic int blank_run();
    return 0;
  endfunction

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int offs[5] = '{0, 1, 2, 3, 5};
    int blanks[3] = '{0, 1, 3};
    foreach (offs[i]) begin
      foreach (blanks[j]) begin
        int exp_off;
        int n;
        int m;
        off_cfg = W'(offs[i]);
        blank_cfg = W'(blanks[j]);
        exp_off = (offs[i] == 0) ? 1 : offs[i];
        trip = 0; comm = 0; pwm = 0;
        rst_n = 0;
        step(); step();
        // R1 reset state
        chk("R1 src_en", int'(src_en), 0);
        chk("R1 chop_off", int'(chop_off), 0);
        chk("R1 blanking", int'(blanking), 0);
        rst_n = 1;
        step();
        chk("R1 src_en after reset", int'(src_en), 0);
        // R2 PWM latency: visible in the second cycle
        pwm = 1;
        step();
        chk("R2 src_en after 1 cycle", int'(src_en), 0);
        step();
        chk("R2 src_en after 2 cycles", int'(src_en), 1);
        for (int k = 0; k < blanks[j] + 3; k++) step();
        chk("R2 blanking settled", int'(blanking), 0);
        // R3/R4/R5 trip held through off-time
        trip = 1;
        step();
        chk("R3 chop_off on trip", int'(chop_off), 1);
        chk("R3 src_en on trip", int'(src_en), 0);
        n = 1;
        for (int k = 0; k < 200; k++) begin
          step();
          if (chop_off) n++;
          else break;
        end
        chk((offs[i] == 0) ? "R4 clamped off-time" : "R5 off-time with held trip", n, exp_off);
        // R6/R8 blanking window with trip still held
        m = 0;
        for (int k = 0; k < 200; k++) begin
          if (!blanking) break;
          if (chop_off) chk("R6 trip ignored in blanking", 1, 0);
          step();
          m++;
        end
        chk("R6 blanking length", m, blanks[j]);
        step();
        chk((blanks[j] == 0) ? "R8 trip accepted without blanking" : "R6 trip accepted after blanking",
            int'(chop_off), 1);
        trip = 0;
        for (int k = 0; k < 200 && chop_off; k++) step();
        for (int k = 0; k < blanks[j] + 2; k++) step();
        // R7 commutation restarts blanking
        comm = 1;
        step();
        comm = 0;
        m = 0;
        for (int k = 0; k < 200 && blanking; k++) begin step(); m++; end
        chk("R7 comm blanking length", m, blanks[j]);
        chk("R7 source on after comm", int'(src_en), 1);
        // R7 comm during off-time leaves off-time unchanged
        trip = 1;
        step();
        trip = 0;
        n = 1;
        comm = 1;
        step();
        comm = 0;
        if (chop_off) n++;
        for (int k = 0; k < 200 && chop_off; k++) begin
          step();
          if (chop_off) n++;
        end
        chk("R7 off-time with comm", n, exp_off);
        m = 0;
        for (int k = 0; k < 200 && blanking; k++) begin step(); m++; end
        chk("R7 blanking after comm in off", m, blanks[j]);
        // R9 trip ignored while PWM low
        pwm = 0;
        step(); step();
        chk("R2 src_en low with PWM low", int'(src_en), 0);
        trip = 1;
        step(); step();
        chk("R9 trip with PWM low", int'(chop_off), 0);
        trip = 0;
        // R7 PWM rise starts blanking one cycle after src_en rises
        pwm = 1;
        step(); step();
        chk("R7 src_en after PWM rise", int'(src_en), 1);
        chk("R7 no blanking in rise cycle", int'(blanking), 0);
        step();
        m = 0;
        for (int k = 0; k < 200 && blanking; k++) begin step(); m++; end
        chk("R7 PWM rise blanking length", m, blanks[j]);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule